// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block classifies a 64-bit virtual address by its top two bits into one of four regions (user, supervisor, unmapped physical window, kernel) and decides, without consulting any translation table, what happens to the access. In the unmapped physical window a three-bit cache-algorithm code carried inside the address chooses how wide the offset is and whether the access is uncached or uncached-accelerated. The decoder then produces the physical address directly. A fixed kernel segment is translated by dropping its base bits. Every other legal address is handed on to the TLB through a need-TLB flag.

Illegal combinations raise an address-error pulse, split into a read and a write flavour. Examples are a reserved algorithm code, an offset beyond the implemented physical range, or a supervisor access from the wrong mode. A prefetch never raises the error; it simply returns nothing. The decode is combinational and its results are captured in one register stage, so a request presented with `req_valid` yields its result one clock later. A parameter selects between the base and the extended processor variant.

Top module: `vsd_segment_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is cleared in the next cycle (rsp_valid, flags and `pa` all zero).
- R2: A request with `req_valid` high gives `rsp_valid` high exactly one cycle later. A cycle with `req_valid` low gives `rsp_valid` low, with all flags and `pa` zero one cycle later.
- R3: The region is `va[63:62]`: 0 user, 1 supervisor, 2 physical window, 3 kernel. A user address, or a kernel address outside the direct segment, sets `need_tlb` with `pa` zero and no other flag.
- R4: A kernel address with `va[63:31]` all ones and `va[30:29]` = 00 is direct-mapped. `pa` equals `va[28:0]` zero-extended, and `need_tlb` and the uncached/accelerated flags stay low.
- R5: In the physical window, algorithm code `va[61:59]` of 3, 4 or 5 (cacheable) gives `pa` = `va[PA_W-1:0]` with both flavor flags low. It is an address error if any of `va[58:PA_W]` is set.
- R6: In the physical window, code 2 (uncached) sets `uncached`, and code 7 sets `uncached` and `accelerated`. Both give `pa` = `va[PA_W-1:0]`, and both are an address error if any of `va[56:PA_W]` is set. The flavor field `va[58:57]` is allowed on the extended variant, but a nonzero value is an address error on the base variant.
- R7: Code 6 (cache update) behaves like a cacheable code on the extended variant and is an address error on the base variant. Codes 0 and 1 are always an address error.
- R8: A supervisor-region access is an address error when `mode32` is high, when `priv_mode[1]` is set (user), when any of `va[61:SUP_VA_W]` is set, or, on the extended variant only, when `sx_enable` is low.
- R9: A supervisor-region access that is not an error sets `need_tlb` with `pa` zero.
- R10: An address error raises `err_write` if `is_write` is high and `err_read` otherwise. Neither is raised when `is_prefetch` is high. On any error `pa`, `need_tlb`, `uncached` and `accelerated` are zero.
- R11: On the base variant `sx_enable` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| va | input | 64 | Virtual address |
| is_write | input | 1 | Access is a store |
| is_prefetch | input | 1 | Access is a prefetch |
| mode32 | input | 1 | Processor runs in 32-bit addressing mode |
| priv_mode | input | 2 | 0 kernel, 1 supervisor, bit 1 set means user |
| sx_enable | input | 1 | Supervisor extended addressing enable |
| rsp_valid | output | 1 | Result of last cycle's request |
| pa | output | PA_W | Physical address for unmapped accesses |
| uncached | output | 1 | Access is uncached |
| accelerated | output | 1 | Access is uncached-accelerated |
| need_tlb | output | 1 | Address must be translated by the TLB |
| err_read | output | 1 | Address error on a load |
| err_write | output | 1 | Address error on a store |

## Verification
Error detection and prefetch suppression fall on the same access whenever a prefetch carries an illegal address. The random mix sets `is_prefetch` on about a quarter of requests while steering a large share of addresses into reserved codes, oversized offsets and forbidden supervisor modes. Such a cycle is judged correct only if both error pulses stay low and `pa` and every flag are zero. The same stimulus drives a base and an extended instance side by side, so flavor bits, the update code and `sx_enable` are judged against two different expected legality outcomes in one cycle.

// File: rtl/vsd_pkg.sv
// Package: shared encodings for the virtual address segment decoder.
// Assumes a 64-bit virtual address whose two top bits name the region.
package vsd_pkg;

    typedef enum logic [1:0] {
        RGN_USER   = 2'd0,
        RGN_SUPER  = 2'd1,
        RGN_PHYS   = 2'd2,
        RGN_KERNEL = 2'd3
    } region_e;

    typedef enum logic [2:0] {
        CA_RSVD0      = 3'd0,
        CA_RSVD1      = 3'd1,
        CA_UNCACHED   = 3'd2,
        CA_NONCOH     = 3'd3,
        CA_EXCL       = 3'd4,
        CA_EXCL_WR    = 3'd5,
        CA_UPDATE     = 3'd6,
        CA_UNC_ACCEL  = 3'd7
    } cache_alg_e;

    // Bit positions inside the virtual address that decoding depends on
    localparam int ALG_HI      = 61;
    localparam int ALG_LO      = 59;
    localparam int FLAVOR_HI   = 58;
    localparam int FLAVOR_LO   = 57;
    localparam int KDIRECT_LSB = 29;

endpackage

// File: rtl/vsd_phys_window.sv
// Module: vsd_phys_window
// Decodes an address in the unmapped physical window. The algorithm code
// selects the offset width and the uncached/accelerated flavor; illegal
// codes, oversized offsets and (base variant) nonzero flavors set bad.
// Assumes PA_W < 57 so the offset checks have a nonempty slice.
module vsd_phys_window
    import vsd_pkg::*;
#(
    parameter int VA_W        = 64,
    parameter int PA_W        = 40,
    parameter bit EXT_VARIANT = 1'b0
) (
    input  logic [VA_W-1:0] va,
    output logic [PA_W-1:0] pa,
    output logic            uncached,
    output logic            accelerated,
    output logic            bad
);

    localparam int NARROW_HI = FLAVOR_HI;
    localparam int WIDE_HI   = FLAVOR_LO - 1;

    cache_alg_e alg;
    logic       narrow_over;
    logic       wide_over;
    logic       flavor_set;
    logic       update_ok;

    assign alg         = cache_alg_e'(va[ALG_HI:ALG_LO]);
    assign narrow_over = |va[NARROW_HI:PA_W];
    assign wide_over   = |va[WIDE_HI:PA_W];
    assign flavor_set  = |va[FLAVOR_HI:FLAVOR_LO];

    // Variant choice for the cache-update code
    generate
        if (EXT_VARIANT) begin : g_upd_ext
            assign update_ok = 1'b1;
        end else begin : g_upd_base
            assign update_ok = 1'b0;
        end
    endgenerate

    // Classify the algorithm code and produce the window translation
    always_comb begin
        pa          = '0;
        uncached    = 1'b0;
        accelerated = 1'b0;
        bad         = 1'b0;
        unique case (alg)
            CA_NONCOH, CA_EXCL, CA_EXCL_WR: begin
                bad = narrow_over;
            end
            CA_UPDATE: begin
                bad = narrow_over | ~update_ok;
            end
            CA_UNCACHED, CA_UNC_ACCEL: begin
                bad         = wide_over | (flavor_set & ~EXT_VARIANT);
                uncached    = 1'b1;
                accelerated = (alg == CA_UNC_ACCEL);
            end
            default: begin
                bad = 1'b1;
            end
        endcase
        if (bad) begin
            uncached    = 1'b0;
            accelerated = 1'b0;
        end else begin
            pa = va[PA_W-1:0];
        end
    end

endmodule

// File: rtl/vsd_super_check.sv
// Module: vsd_super_check
// Legality of a supervisor-region access: mode, privilege, unused upper
// address bits and, on the extended variant, the extended-enable bit.
// Assumes SUP_VA_W <= VA_W-3.
module vsd_super_check #(
    parameter int VA_W        = 64,
    parameter int SUP_VA_W    = 40,
    parameter bit EXT_VARIANT = 1'b0
) (
    input  logic [VA_W-1:0] va,
    input  logic            mode32,
    input  logic [1:0]      priv_mode,
    input  logic            sx_enable,
    output logic            bad
);

    localparam int HOLE_HI = VA_W - 3;

    logic hole_set;
    logic sx_block;

    assign hole_set = |va[HOLE_HI:SUP_VA_W];

    // Extended-enable gate exists only on the extended variant
    generate
        if (EXT_VARIANT) begin : g_sx_ext
            assign sx_block = ~sx_enable;
        end else begin : g_sx_base
            logic unused_sx;
            assign unused_sx = sx_enable;
            assign sx_block  = 1'b0;
        end
    endgenerate

    // Combine the independent illegality causes
    always_comb begin
        bad = mode32 | priv_mode[1] | hole_set | sx_block;
    end

endmodule

// File: rtl/vsd_kernel_direct.sv
// Module: vsd_kernel_direct
// Detects the fixed kernel direct-mapped segment and strips its base bits.
// Assumes PA_W > KDIRECT_LSB.
module vsd_kernel_direct
    import vsd_pkg::*;
#(
    parameter int VA_W = 64,
    parameter int PA_W = 40
) (
    input  logic [VA_W-1:0] va,
    output logic            hit,
    output logic [PA_W-1:0] pa
);

    localparam int BASE_W = VA_W - KDIRECT_LSB;
    localparam logic [BASE_W-1:0] SEG_BASE = {{(BASE_W-2){1'b1}}, 2'b00};

    // Match the segment base and form the offset
    always_comb begin
        hit = (va[VA_W-1:KDIRECT_LSB] == SEG_BASE);
        pa  = '0;
        if (hit) begin
            pa[KDIRECT_LSB-1:0] = va[KDIRECT_LSB-1:0];
        end
    end

endmodule

// File: rtl/vsd_segment_decoder.sv
// Module: vsd_segment_decoder (top)
// Classifies a virtual address into its region, translates unmapped
// addresses, flags TLB-mapped ones and raises read/write address errors
// (never for prefetches). Results are registered: one cycle latency.
// Assumes a synchronous active-low reset.
module vsd_segment_decoder
    import vsd_pkg::*;
#(
    parameter int VA_W        = 64,
    parameter int PA_W        = 40,
    parameter int SUP_VA_W    = 40,
    parameter bit EXT_VARIANT = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VA_W-1:0] va,
    input  logic            is_write,
    input  logic            is_prefetch,
    input  logic            mode32,
    input  logic [1:0]      priv_mode,
    input  logic            sx_enable,
    output logic            rsp_valid,
    output logic [PA_W-1:0] pa,
    output logic            uncached,
    output logic            accelerated,
    output logic            need_tlb,
    output logic            err_read,
    output logic            err_write
);

    region_e         region;
    logic [PA_W-1:0] pw_pa;
    logic            pw_unc;
    logic            pw_acc;
    logic            pw_bad;
    logic            sup_bad;
    logic            kd_hit;
    logic [PA_W-1:0] kd_pa;

    logic [PA_W-1:0] nxt_pa;
    logic            nxt_unc;
    logic            nxt_acc;
    logic            nxt_tlb;
    logic            nxt_bad;

    assign region = region_e'(va[VA_W-1:VA_W-2]);

    vsd_phys_window #(
        .VA_W(VA_W), .PA_W(PA_W), .EXT_VARIANT(EXT_VARIANT)
    ) i_phys (
        .va(va), .pa(pw_pa), .uncached(pw_unc),
        .accelerated(pw_acc), .bad(pw_bad)
    );

    vsd_super_check #(
        .VA_W(VA_W), .SUP_VA_W(SUP_VA_W), .EXT_VARIANT(EXT_VARIANT)
    ) i_super (
        .va(va), .mode32(mode32), .priv_mode(priv_mode),
        .sx_enable(sx_enable), .bad(sup_bad)
    );

    vsd_kernel_direct #(
        .VA_W(VA_W), .PA_W(PA_W)
    ) i_kdir (
        .va(va), .hit(kd_hit), .pa(kd_pa)
    );

    // Select the per-region outcome
    always_comb begin
        nxt_pa  = '0;
        nxt_unc = 1'b0;
        nxt_acc = 1'b0;
        nxt_tlb = 1'b0;
        nxt_bad = 1'b0;
        unique case (region)
            RGN_PHYS: begin
                nxt_bad = pw_bad;
                nxt_pa  = pw_pa;
                nxt_unc = pw_unc;
                nxt_acc = pw_acc;
            end
            RGN_SUPER: begin
                nxt_bad = sup_bad;
                nxt_tlb = ~sup_bad;
            end
            RGN_KERNEL: begin
                nxt_pa  = kd_pa;
                nxt_tlb = ~kd_hit;
            end
            default: begin
                nxt_tlb = 1'b1;
            end
        endcase
    end

    // Capture the decode result; idle cycles and reset clear everything
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid   <= 1'b0;
            pa          <= '0;
            uncached    <= 1'b0;
            accelerated <= 1'b0;
            need_tlb    <= 1'b0;
            err_read    <= 1'b0;
            err_write   <= 1'b0;
        end else begin
            rsp_valid   <= 1'b1;
            pa          <= nxt_pa;
            uncached    <= nxt_unc;
            accelerated <= nxt_acc;
            need_tlb    <= nxt_tlb;
            err_read    <= nxt_bad & ~is_write & ~is_prefetch;
            err_write   <= nxt_bad &  is_write & ~is_prefetch;
        end
    end

endmodule

// File: rtl/vsd_segment_decoder_chk.sv
// Module: vsd_segment_decoder_chk
// Temporal checks on the decoder ports, bound to every decoder instance.
module vsd_segment_decoder_chk #(
    parameter int VA_W = 64,
    parameter int PA_W = 40
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] va,
    input logic            is_write,
    input logic            is_prefetch,
    input logic            mode32,
    input logic            rsp_valid,
    input logic [PA_W-1:0] pa,
    input logic            uncached,
    input logic            accelerated,
    input logic            need_tlb,
    input logic            err_read,
    input logic            err_write
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!err_read && !err_write && !need_tlb && !uncached && !accelerated && pa == '0)); // R2
    AST_TLB_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        need_tlb |-> (pa == '0 && !uncached && !accelerated)); // R3
    AST_ACCEL_UNC: assert property (@(posedge clk) disable iff (!rst_n)
        accelerated |-> uncached); // R6
    AST_SUPER_MODE32: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !is_prefetch && va[VA_W-1:VA_W-2] == 2'b01 && mode32) |=> (err_read || err_write)); // R8
    AST_PREFETCH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_prefetch) |=> (!err_read && !err_write)); // R10
    AST_READ_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !is_write) |=> !err_write); // R10
    AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (err_read || err_write) |-> (pa == '0 && !need_tlb && !uncached && !accelerated && !(err_read && err_write))); // R10

endmodule

bind vsd_segment_decoder vsd_segment_decoder_chk #(.VA_W(VA_W), .PA_W(PA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .va(va),
    .is_write(is_write), .is_prefetch(is_prefetch), .mode32(mode32),
    .rsp_valid(rsp_valid), .pa(pa), .uncached(uncached),
    .accelerated(accelerated), .need_tlb(need_tlb),
    .err_read(err_read), .err_write(err_write)
);

// File: tb/test_vsd_segment_decoder.sv
`timescale 1ns/1ps
// Bench: base and extended decoders driven in parallel, directed corner
// cases followed by seeded random traffic, checked against a model.
module test_vsd_segment_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] va = '0;
    logic        is_write = 1'b0;
    logic        is_prefetch = 1'b0;
    logic        mode32 = 1'b0;
    logic [1:0]  priv_mode = 2'd0;
    logic        sx_enable = 1'b0;

    logic        rv_b, unc_b, acc_b, tlb_b, er_b, ew_b;
    logic [39:0] pa_b;
    logic        rv_e, unc_e, acc_e, tlb_e, er_e, ew_e;
    logic [39:0] pa_e;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    vsd_segment_decoder #(.EXT_VARIANT(1'b0)) i_vsd_segment_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .va(va),
        .is_write(is_write), .is_prefetch(is_prefetch), .mode32(mode32),
        .priv_mode(priv_mode), .sx_enable(sx_enable),
        .rsp_valid(rv_b), .pa(pa_b), .uncached(unc_b), .accelerated(acc_b),
        .need_tlb(tlb_b), .err_read(er_b), .err_write(ew_b)
    );

    vsd_segment_decoder #(.EXT_VARIANT(1'b1)) i_vsd_segment_decoder_ext (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .va(va),
        .is_write(is_write), .is_prefetch(is_prefetch), .mode32(mode32),
        .priv_mode(priv_mode), .sx_enable(sx_enable),
        .rsp_valid(rv_e), .pa(pa_e), .uncached(unc_e), .accelerated(acc_e),
        .need_tlb(tlb_e), .err_read(er_e), .err_write(ew_e)
    );

    // Expected {rsp_valid, err_read, err_write, need_tlb, uncached, accelerated, pa}
    function automatic logic [45:0] model(input logic [63:0] v, input logic w, input logic pf,
                                          input logic m32, input logic [1:0] pr, input logic sx,
                                          input bit ext);
        logic bad, tlb, u, a;
        logic [39:0] p;
        logic [2:0] code;
        bad = 0; tlb = 0; u = 0; a = 0; p = '0;
        code = v[61:59];
        case (v[63:62])
            2'd0: tlb = 1;
            2'd1: begin
                if (m32 || pr[1] || v[61:40] != 0 || (ext && !sx)) bad = 1;
                else tlb = 1;
            end
            2'd2: begin
                if (code == 3 || code == 4 || code == 5 || (code == 6 && ext)) begin
                    if (v[58:40] != 0) bad = 1; else p = v[39:0];
                end else if (code == 2 || code == 7) begin
                    if (v[56:40] != 0 || (!ext && v[58:57] != 0)) bad = 1;
                    else begin p = v[39:0]; u = 1; a = (code == 7); end
                end else bad = 1;
            end
            default: begin
                if (v[63:29] == {33'h1_FFFF_FFFF, 2'b00}) p = {11'd0, v[28:0]};
                else tlb = 1;
            end
        endcase
        return {1'b1, bad & !w & !pf, bad & w & !pf, tlb, u, a, p};
    endfunction

    task automatic check(input string req, input logic [45:0] got, input logic [45:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    // Drive one request at a falling edge, compare both instances one cycle later
    task automatic run(input string req, input logic [63:0] v, input logic w, input logic pf,
                       input logic m32, input logic [1:0] pr, input logic sx);
        logic [45:0] eb, ee;
        req_valid = 1'b1; va = v; is_write = w; is_prefetch = pf;
        mode32 = m32; priv_mode = pr; sx_enable = sx;
        eb = model(v, w, pf, m32, pr, sx, 1'b0);
        ee = model(v, w, pf, m32, pr, sx, 1'b1);
        @(negedge clk);
        check({req, " base"}, {rv_b, er_b, ew_b, tlb_b, unc_b, acc_b, pa_b}, eb);
        check({req, " ext"},  {rv_e, er_e, ew_e, tlb_e, unc_e, acc_e, pa_e}, ee);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    function automatic logic [63:0] gen_va();
        logic [63:0] r;
        r = rnd64();
        case ($urandom % 4)
            0: return {2'b00, r[61:0]};
            1: return {2'b01, (($urandom % 4) == 0) ? r[61:40] : 22'd0, r[39:0]};
            2: return {2'b10, 3'($urandom % 8), (($urandom % 2) == 0) ? 2'($urandom) : 2'd0,
                       (($urandom % 4) == 0) ? r[56:40] : 17'd0, r[39:0]};
            default: return (($urandom % 2) == 0) ? {33'h1_FFFF_FFFF, 2'b00, r[28:0]} : {2'b11, r[61:0]};
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        req_valid = 1'b1; va = 64'h8000_0000_0000_1000;
        repeat (3) @(negedge clk);
        // R1: reset state even with a request present
        check("R1 reset base", {rv_b, er_b, ew_b, tlb_b, unc_b, acc_b, pa_b}, 46'd0);
        check("R1 reset ext",  {rv_e, er_e, ew_e, tlb_e, unc_e, acc_e, pa_e}, 46'd0);
        rst_n = 1'b1;
        req_valid = 1'b0; va = 64'h9800_0000_0000_1000;
        @(negedge clk);
        // R2: idle cycle gives nothing
        check("R2 idle", {rv_b, er_b, ew_b, tlb_b, unc_b, acc_b, pa_b}, 46'd0);

        run("R3 user", 64'h0000_0000_0040_0000, 0, 0, 0, 2'd2, 0);
        run("R3 kernel mapped", 64'hFFFF_FFFF_C000_0000, 0, 0, 0, 2'd0, 0);
        run("R4 kernel direct", 64'hFFFF_FFFF_9FFF_FFFC, 0, 0, 0, 2'd0, 0);
        run("R4 kernel direct base", 64'hFFFF_FFFF_8000_0000, 1, 0, 0, 2'd0, 0);
        run("R5 cacheable", 64'h9800_00AB_CDEF_0123, 0, 0, 0, 2'd0, 0);
        run("R5 offset over", 64'hA000_0100_0000_0000, 1, 0, 0, 2'd0, 0);
        run("R6 uncached", 64'h9000_00FF_FFFF_FFFF, 0, 0, 0, 2'd0, 0);
        run("R6 accel", 64'hB800_0012_3456_7890, 0, 0, 0, 2'd0, 0);
        run("R6 flavor", 64'h9600_0000_0000_0040, 1, 0, 0, 2'd0, 0);
        run("R6 wide over", 64'h9000_0100_0000_0000, 0, 0, 0, 2'd0, 0);
        run("R7 update", 64'hB000_0000_1234_0000, 0, 0, 0, 2'd0, 0);
        run("R7 rsvd0", 64'h8000_0000_0000_0000, 1, 0, 0, 2'd0, 0);
        run("R7 rsvd1", 64'h8800_0000_0000_0000, 0, 0, 0, 2'd0, 0);
        run("R8 mode32", 64'h4000_0000_0000_1000, 0, 0, 1, 2'd1, 1);
        run("R8 user", 64'h4000_0000_0000_1000, 1, 0, 0, 2'd2, 1);
        run("R8 hole", 64'h4000_0100_0000_1000, 0, 0, 0, 2'd0, 1);
        run("R8 sx clear", 64'h4000_0000_0000_1000, 1, 0, 0, 2'd1, 0);
        run("R9 supervisor ok", 64'h4000_00FF_0000_0000, 0, 0, 0, 2'd1, 1);
        run("R10 prefetch error", 64'h8000_0000_0000_0000, 1, 1, 0, 2'd0, 0);
        run("R10 prefetch super", 64'h4000_0000_0000_0000, 0, 1, 1, 2'd2, 0);
        run("R11 sx low", 64'h4000_0012_0000_0000, 0, 0, 0, 2'd0, 0);
        run("R11 sx high", 64'h4000_0012_0000_0000, 0, 0, 0, 2'd0, 1);

        // Seeded random mix: regions, codes, modes, directions, prefetches
        for (int i = 0; i < 3000; i++) begin
            run("random R3 R5 R6 R7 R8 R10", gen_va(), 1'($urandom), ($urandom % 4) == 0,
                ($urandom % 4) == 0, 2'($urandom), 1'($urandom));
            if (($urandom % 8) == 0) begin
                req_valid = 1'b0; va = rnd64();
                @(negedge clk);
                check("R2 random idle", {rv_e, er_e, ew_e, tlb_e, unc_e, acc_e, pa_e}, 46'd0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule